// File: doc/BRIEF.md
# Interrupt Summary and Mask Register Bank

This block collects nineteen level-sensitive interrupt requests and presents them to software as three consecutive byte-wide I/O registers. The requests come from four expansion slots, each with four request lines (A to D), and from three on-board agents: a bridge cascade, a disk controller and a USB controller. Every request passes through a two-flop synchronizer. The synchronized levels drive both the read path and a single combined interrupt line to the processor.

A read of any of the three registers returns the live, unmasked request levels packed into that byte. A write to a register loads the mask byte at that address. In the mask, a 1 disables the source and a 0 enables it. The mask cannot be read back, so driver software has to keep its own copy of it. The combined output is high whenever at least one enabled source is pending. Because the requests are levels, the output stays high until the device releases its line or software masks the source.

Top module: `irq_summary_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `irq_out` is 0. Reset sets every mask bit to 1 and clears the synchronizer, so reads return 0x00 until requests propagate.
- R2: A read at BASE_ADDR (0x804) returns: bits 3:0 = slot 0..3 line A, bit 4 = bridge cascade, bit 5 = disk controller, bit 6 = USB, bit 7 = slot 0 line B.
- R3: A read at BASE_ADDR+1 (0x805) returns: bits 2:0 = slot 1..3 line B, bits 6:3 = slot 0..3 line C, bit 7 = slot 0 line D.
- R4: A read at BASE_ADDR+2 (0x806) returns slot 1..3 line D in bits 2:0, and 0 in reserved bits 7:3.
- R5: A write with `wr_en` high to one of the three addresses loads the mask byte at that address on that clock edge. Reads keep returning raw request levels whatever the mask holds.
- R6: `irq_out` is 1 exactly when some synchronized source is 1 and its mask bit is 0. A mask bit of 1 removes that source from the output.
- R7: Writes to the reserved mask positions (bits 7:3 of the third register) have no effect on `irq_out` or on read data.
- R8: A change on a request input appears in read data and in `irq_out` two clock edges after it is sampled. It is not visible after one edge.
- R9: With `rd_en` high, a read at an address outside the three registers returns 0x00. A write to such an address changes no mask bit.
- R10: A request counts as pending for as long as its line is held. `irq_out` stays high while an enabled line stays high, and falls two edges after the line is released.
- R11: While `rd_en` is low, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (12) | I/O address shared by reads and writes |
| rd_en | input | 1 | Read strobe; `rd_data` is combinational while high |
| wr_en | input | 1 | Write strobe; mask loads on the clock edge |
| wr_data | input | 8 | Mask byte to write |
| rd_data | output | 8 | Raw request byte for the addressed register |
| slot_a_req | input | 4 | Line A requests from slots 3..0 |
| slot_b_req | input | 4 | Line B requests from slots 3..0 |
| slot_c_req | input | 4 | Line C requests from slots 3..0 |
| slot_d_req | input | 4 | Line D requests from slots 3..0 |
| bridge_req | input | 1 | Bridge cascade request |
| disk_req | input | 1 | Disk controller request |
| usb_req | input | 1 | USB controller request |
| irq_out | output | 1 | Combined request to the processor |

## Verification
Some properties are checked on every cycle: the quiet output during and just after reset, the zero read for unmatched addresses and idle strobes, the zero reserved bits, the two-edge delay from request pins to the first register, and the silent output once all requests have been low for two samples. The bench's scenarios are the only place several other behaviours show up. These are the packing of every source into its byte, mask loads at each address, the fact that the mask never appears in read data, writes ignored at reserved positions or at stray addresses, and the output following levels as they rise and fall. The bench shows them by comparing every cycle against a behavioural model.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;

    localparam int SLOTS     = 4;
    localparam int BYTE_W    = 8;
    localparam int NUM_REGS  = 3;
    localparam int NUM_SRC   = 4 * SLOTS + 3;
    localparam int IMG_W     = NUM_REGS * BYTE_W;
    localparam int IDX_W     = $clog2(NUM_REGS);

    // Positions in the packed register image that carry a source.
    localparam logic [IMG_W-1:0] IMG_VALID = IMG_W'((64'd1 << NUM_SRC) - 64'd1);

    // Raw request bundle, one field per source group.
    typedef struct packed {
        logic             usb;
        logic             disk;
        logic             bridge;
        logic [SLOTS-1:0] line_d;
        logic [SLOTS-1:0] line_c;
        logic [SLOTS-1:0] line_b;
        logic [SLOTS-1:0] line_a;
    } irq_src_t;

    // Result of address decode.
    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    // Pack the sources into the software-visible register image.
    function automatic logic [IMG_W-1:0] pack_image(input irq_src_t s);
        logic [IMG_W-1:0] img;
        img          = '0;
        img[3:0]     = s.line_a;
        img[4]       = s.bridge;
        img[5]       = s.disk;
        img[6]       = s.usb;
        img[7]       = s.line_b[0];
        img[10:8]    = s.line_b[3:1];
        img[14:11]   = s.line_c;
        img[15]      = s.line_d[0];
        img[18:16]   = s.line_d[3:1];
        return img;
    endfunction

    // Implemented bits of one register byte.
    function automatic logic [BYTE_W-1:0] byte_valid(input int idx);
        return IMG_VALID[idx*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/irqsum_sync.sv
module irqsum_sync #(
    parameter int WIDTH  = 19,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irqsum_mask_bank.sv
module irqsum_mask_bank
    import irqsum_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_t          sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [IMG_W-1:0]  mask_img
);

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_byte
            localparam logic [BYTE_W-1:0] VALID = byte_valid(g);
            logic [BYTE_W-1:0] m_q;
            logic              load;

            assign load = wr_en && sel.hit && (sel.idx == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (rst) begin
                    m_q <= '1;
                end else if (load) begin
                    // Reserved positions stay at 1 (disabled).
                    m_q <= (wr_data & VALID) | ~VALID;
                end
            end

            assign mask_img[g*BYTE_W +: BYTE_W] = m_q;
        end
    endgenerate

endmodule

// File: rtl/irqsum_combine.sv
module irqsum_combine
    import irqsum_pkg::*;
(
    input  logic [IMG_W-1:0]  img,
    input  logic [IMG_W-1:0]  mask_img,
    input  logic              rd_en,
    input  reg_sel_t          sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq_out
);

    logic [IMG_W-1:0] live;

    assign live    = img & ~mask_img & IMG_VALID;
    assign irq_out = |live;

    always_comb begin
        rd_data = '0;
        if (rd_en && sel.hit) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (sel.idx == IDX_W'(i)) begin
                    rd_data = img[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end

endmodule

// File: rtl/irq_summary_bank.sv
module irq_summary_bank
    import irqsum_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h804,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [SLOTS-1:0]  slot_a_req,
    input  logic [SLOTS-1:0]  slot_b_req,
    input  logic [SLOTS-1:0]  slot_c_req,
    input  logic [SLOTS-1:0]  slot_d_req,
    input  logic              bridge_req,
    input  logic              disk_req,
    input  logic              usb_req,
    output logic              irq_out
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(NUM_REGS - 1);

    irq_src_t          raw_src;
    irq_src_t          sync_src;
    logic [IMG_W-1:0]  img;
    logic [IMG_W-1:0]  mask_img;
    reg_sel_t          sel;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        raw_src.usb    = usb_req;
        raw_src.disk   = disk_req;
        raw_src.bridge = bridge_req;
        raw_src.line_d = slot_d_req;
        raw_src.line_c = slot_c_req;
        raw_src.line_b = slot_b_req;
        raw_src.line_a = slot_a_req;
    end

    irqsum_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_src),
        .q   (sync_src)
    );

    assign img = pack_image(sync_src);

    // Address decode.
    assign offset  = addr - BASE_ADDR;
    assign sel.hit = (addr >= BASE_ADDR) && (addr <= LAST_ADDR);
    assign sel.idx = offset[IDX_W-1:0];

    irqsum_mask_bank u_mask (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .sel      (sel),
        .wr_data  (wr_data),
        .mask_img (mask_img)
    );

    irqsum_combine u_comb (
        .img      (img),
        .mask_img (mask_img),
        .rd_en    (rd_en),
        .sel      (sel),
        .rd_data  (rd_data),
        .irq_out  (irq_out)
    );

endmodule

// File: rtl/irq_summary_bank_chk.sv
module irq_summary_bank_chk #(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h804
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic [7:0]        rd_data,
    input logic [3:0]        slot_a_req,
    input logic [3:0]        slot_b_req,
    input logic [3:0]        slot_c_req,
    input logic [3:0]        slot_d_req,
    input logic              bridge_req,
    input logic              disk_req,
    input logic              usb_req,
    input logic              irq_out
);

    localparam logic [ADDR_W-1:0] HI_ADDR   = BASE_ADDR + ADDR_W'(2);

    logic       any_raw;
    logic       in_range;
    logic [1:0] settle;

    assign any_raw  = |{slot_a_req, slot_b_req, slot_c_req, slot_d_req,
                        bridge_req, disk_req, usb_req};
    assign in_range = (addr >= BASE_ADDR) && (addr <= HI_ADDR);

    always_ff @(posedge clk) begin
        if (rst) settle <= '0;
        else if (settle != 2'd2) settle <= settle + 2'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !irq_out);

    // R11
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == 8'h00));

    // R9
    stray_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !in_range) |-> (rd_data == 8'h00));

    // R4
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == HI_ADDR) |-> (rd_data[7:3] == 5'd0));

    // R8
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd2 && rd_en && addr == BASE_ADDR) |->
        (rd_data[0] == $past(slot_a_req[0], 2) && rd_data[4] == $past(bridge_req, 2)));

    // R10
    quiet_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd2 && !any_raw && !$past(any_raw)) |=> !irq_out);

endmodule

bind irq_summary_bank irq_summary_bank_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .slot_a_req (slot_a_req),
    .slot_b_req (slot_b_req),
    .slot_c_req (slot_c_req),
    .slot_d_req (slot_d_req),
    .bridge_req (bridge_req),
    .disk_req   (disk_req),
    .usb_req    (usb_req),
    .irq_out    (irq_out)
);

// File: tb/irq_summary_bank_bench.sv
`timescale 1ns/1ps
module irq_summary_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = 12'h000;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [3:0]  sa = '0, sb = '0, sc = '0, sd = '0;
    logic        br = 1'b0, dk = 1'b0, us = 1'b0;
    logic        irq_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_summary_bank u_irq_summary_bank (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .slot_a_req(sa), .slot_b_req(sb), .slot_c_req(sc), .slot_d_req(sd),
        .bridge_req(br), .disk_req(dk), .usb_req(us), .irq_out(irq_out)
    );

    // Behavioural model: bench order {usb, disk, bridge, D, C, B, A}.
    logic [18:0] p1 = '0, p2 = '0;
    logic [7:0]  mk [3];

    function automatic logic src_at(input logic [18:0] p, input int r, input int b);
        int n;
        n = r * 8 + b;
        if (n <= 3)  return p[n];            // line A
        if (n == 4)  return p[16];           // bridge
        if (n == 5)  return p[17];           // disk
        if (n == 6)  return p[18];           // usb
        if (n <= 18) return p[n - 3];        // B0..B3, C0..C3, D0..D3
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_byte(input int r);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[b] = src_at(p2, r, b);
        return v;
    endfunction

    function automatic logic exp_irq();
        for (int r = 0; r < 3; r++)
            for (int b = 0; b < 8; b++)
                if (src_at(p2, r, b) && !mk[r][b]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(input string tag);
        int r;
        logic [7:0] er;
        @(posedge clk);
        r = int'(addr) - 'h804;
        if (rst) begin
            p1 = '0; p2 = '0;
            for (int i = 0; i < 3; i++) mk[i] = 8'hFF;
        end else begin
            p2 = p1;
            p1 = {us, dk, br, sd, sc, sb, sa};
            if (wr_en && r >= 0 && r < 3) mk[r] = wr_data;
        end
        @(negedge clk);
        er = (rd_en && r >= 0 && r < 3) ? exp_byte(r) : 8'h00;
        vectors++;
        if (rd_data !== er) begin
            miscompares++;
            $display("FAIL %s rd_data=%02h expected %02h (addr %03h)", tag, rd_data, er, addr);
        end
        if (irq_out !== exp_irq()) begin
            miscompares++;
            $display("FAIL %s irq_out=%0b expected %0b", tag, irq_out, exp_irq());
        end
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        step(tag);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input string tag);
        addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
        step(tag);
        wr_en = 1'b0;
    endtask

    task automatic srcs(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                        input logic [3:0] d, input logic x, input logic y, input logic z);
        sa = a; sb = b; sc = c; sd = d; br = x; dk = y; us = z;
    endtask

    initial begin
        // R1: reset state, with a stray write during reset.
        wr_en = 1'b1; addr = 12'h804; wr_data = 8'h00;
        srcs(4'h0, 4'h0, 4'h0, 4'h0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step("R1");
        wr_en = 1'b0;
        rst = 1'b0;
        rd(12'h804, "R1"); rd(12'h805, "R1"); rd(12'h806, "R1");

        // R1/R6: sources high but every mask bit still 1 from reset.
        srcs(4'hF, 4'hF, 4'hF, 4'hF, 1, 1, 1);
        for (int i = 0; i < 3; i++) rd(12'h806, "R6");
        srcs(4'h0, 4'h0, 4'h0, 4'h0, 0, 0, 0);
        for (int i = 0; i < 3; i++) rd(12'h804, "R10");

        // R8: one line, observe each edge.
        srcs(4'h1, 4'h0, 4'h0, 4'h0, 0, 0, 0);
        rd(12'h804, "R8"); rd(12'h804, "R8"); rd(12'h804, "R8");

        // R2: byte 0 packing.
        srcs(4'hA, 4'h1, 4'h0, 4'h0, 1, 0, 1);
        for (int i = 0; i < 3; i++) rd(12'h804, "R2");
        srcs(4'h5, 4'h0, 4'h0, 4'h0, 0, 1, 0);
        for (int i = 0; i < 3; i++) rd(12'h804, "R2");

        // R3: byte 1 packing.
        srcs(4'h0, 4'hE, 4'h9, 4'h1, 0, 0, 0);
        for (int i = 0; i < 3; i++) rd(12'h805, "R3");
        srcs(4'h0, 4'h4, 4'h6, 4'h0, 0, 0, 0);
        for (int i = 0; i < 3; i++) rd(12'h805, "R3");

        // R4: byte 2 packing and reserved zeros.
        srcs(4'hF, 4'hF, 4'hF, 4'hE, 1, 1, 1);
        for (int i = 0; i < 3; i++) rd(12'h806, "R4");
        srcs(4'h0, 4'h0, 4'h0, 4'hA, 0, 0, 0);
        for (int i = 0; i < 2; i++) rd(12'h806, "R4");

        // R5: mask writes do not show in read data.
        wr(12'h804, 8'h00, "R5");
        wr(12'h805, 8'h00, "R5");
        rd(12'h804, "R5"); rd(12'h805, "R5"); rd(12'h806, "R5");

        // R6: single unmasked source, others masked.
        wr(12'h806, 8'h07, "R6");
        wr(12'h805, 8'hFF, "R6");
        wr(12'h804, 8'hDF, "R6");          // only disk enabled
        srcs(4'hF, 4'hF, 4'hF, 4'hF, 1, 0, 1);
        for (int i = 0; i < 3; i++) rd(12'h804, "R6");
        srcs(4'h0, 4'h0, 4'h0, 4'h0, 0, 1, 0);
        for (int i = 0; i < 3; i++) rd(12'h804, "R6");
        wr(12'h804, 8'hFF, "R6");           // mask it again
        rd(12'h804, "R6");

        // R10: level held, then released.
        wr(12'h806, 8'hFB, "R10");          // enable slot 3 line D
        srcs(4'h0, 4'h0, 4'h0, 4'h8, 0, 0, 0);
        for (int i = 0; i < 5; i++) rd(12'h806, "R10");
        srcs(4'h0, 4'h0, 4'h0, 4'h0, 0, 0, 0);
        for (int i = 0; i < 3; i++) rd(12'h806, "R10");

        // R7: reserved mask positions have no effect.
        wr(12'h806, 8'h07, "R7");
        srcs(4'hF, 4'hF, 4'hF, 4'hF, 1, 1, 1);
        for (int i = 0; i < 3; i++) rd(12'h806, "R7");
        wr(12'h806, 8'h00, "R7");
        wr(12'h806, 8'hFF, "R7");
        wr(12'h806, 8'h07, "R7");
        rd(12'h806, "R7");

        // R9: stray addresses.
        wr(12'h807, 8'h00, "R9");
        wr(12'h803, 8'h00, "R9");
        wr(12'h004, 8'h00, "R9");
        rd(12'h807, "R9"); rd(12'h803, "R9"); rd(12'hC04, "R9");

        // R11: no strobe, address in range.
        addr = 12'h804;
        step("R11"); step("R11");

        // Wrap up: enable all, then drop everything.
        wr(12'h805, 8'h00, "R6");
        rd(12'h805, "R6");
        srcs(4'h0, 4'h0, 4'h0, 4'h0, 0, 0, 0);
        for (int i = 0; i < 3; i++) rd(12'h805, "R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule